// File: doc/BRIEF.md
# Sized Integer Adder-Subtractor With Status Flags

This block carries out the add and subtract family of integer operations on 8-, 16- or 32-bit operands, picked per operation by a size code. It covers plain add and subtract, their carry-chained forms, increment, decrement and two's-complement negate. Along with the result it produces six status flags: carry, parity, nibble (auxiliary) carry, zero, sign and overflow. All flags are taken at the selected operand size.

A flags register upstream feeds the current flag vector in. The block returns the updated vector and a write mask naming the flags the operation actually defines. Positions outside the mask are copied through from the input, so the caller may either write the whole vector back or merge it under the mask. Chained carry operations let a wide sum or difference be built from successive 32-bit steps, with each step's carry output fed into the next. The outputs are registered: an operation presented at one rising edge shows at the outputs after that edge.

Top module: `alu_flag_unit`

## Requirements
- R1: The opcode is 3 bits: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 increment, 5 decrement, 6 negate, 7 no operation. The size code is 2 bits: 0 selects 8 bits, 1 selects 16 bits, 2 and 3 select 32 bits. The result equals the arithmetic result modulo 2^size. Result bits above the size are zero, and operand bits above the size have no effect.
- R2: Carry is flag bit 0. For add forms it is the carry out of the size's top bit. For subtract forms it is set when the minuend is below the subtrahend (plus borrow-in) as unsigned values.
- R3: Overflow is flag bit 5. It is set when the signed result at the selected size falls out of range.
- R4: Sign is flag bit 4 and copies the result's top bit at the selected size. Zero is flag bit 3 and is set exactly when the result is zero.
- R5: Auxiliary carry is flag bit 2. It is set on a carry out of bit 3 for add forms, or on a borrow into bit 3 for subtract forms.
- R6: Parity is flag bit 1. It is set when bits 7..0 of the result hold an even number of ones, whatever the size.
- R7: Add-with-carry adds incoming flag bit 0 to the sum. Subtract-with-borrow also subtracts it. This makes chained multiword arithmetic give the exact wide result.
- R8: Increment and decrement never alter carry. Their write mask is 6'b111110, and output flag bit 0 equals input flag bit 0. All other non-idle opcodes give a mask of 6'b111111.
- R9: Negate returns zero minus the operand. It sets carry exactly when the operand (at the selected size) is nonzero, and sets overflow for the most negative value.
- R10: Opcode 7 gives a zero result and a zero write mask, and passes the input flags through unchanged.
- R11: Outputs update on the rising clock edge after the inputs are presented. A synchronous active-high reset clears the result, flags and mask to zero, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand size code |
| a_i | input | 32 | Destination / first operand |
| b_i | input | 32 | Source / second operand |
| flags_i | input | 6 | Current flags {OF,SF,ZF,AF,PF,CF} |
| result_o | output | 32 | Registered result, zero above the size |
| flags_o | output | 6 | Registered updated flags |
| flag_mask_o | output | 6 | Registered mask of flags defined by the operation |

## Verification
The four binary forms are swept at 8 bits over every first operand against a stride of second operands, with both values of the incoming carry. This separates the carry and borrow rules from one another and from the incoming-carry handling. Random bits are placed above the byte, so any leak past the size shows up. The unary forms are swept over all 256 byte values, which isolates the carry behaviour of increment and decrement and the nonzero rule of negate. At 16 and 32 bits a set of corner values around zero, the sign boundary and all-ones is crossed with every opcode. This shows that the top-bit and nibble taps move with the size. A two-step 64-bit add and subtract confirms that chaining gives the exact wide result.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_INC  = 3'd4,
    OP_DEC  = 3'd5,
    OP_NEG  = 3'd6,
    OP_NONE = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SZ_Q   = 2'd0,
    SZ_H   = 2'd1,
    SZ_F   = 2'd2,
    SZ_F2  = 2'd3
  } alu_size_e;

  localparam int FLAG_W = 6;
  localparam int FL_CF  = 0;
  localparam int FL_PF  = 1;
  localparam int FL_AF  = 2;
  localparam int FL_ZF  = 3;
  localparam int FL_SF  = 4;
  localparam int FL_OF  = 5;

endpackage

// File: rtl/alu_size_decode.sv
module alu_size_decode #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] msb_sel_o
);
  import alu_flag_pkg::*;

  localparam int QW = DATA_W / 4;
  localparam int HW = DATA_W / 2;

  always_comb begin
    case (size_i)
      SZ_Q: begin
        mask_o    = {{(DATA_W-QW){1'b0}}, {QW{1'b1}}};
        msb_sel_o = DATA_W'(1) << (QW - 1);
      end
      SZ_H: begin
        mask_o    = {{(DATA_W-HW){1'b0}}, {HW{1'b1}}};
        msb_sel_o = DATA_W'(1) << (HW - 1);
      end
      default: begin
        mask_o    = {DATA_W{1'b1}};
        msb_sel_o = DATA_W'(1) << (DATA_W - 1);
      end
    endcase
  end

endmodule

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cf_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] x_o,
  output logic [DATA_W-1:0] y_o,
  output logic              cin_o,
  output logic              is_sub_o,
  output logic              keep_cf_o,
  output logic              valid_o
);
  import alu_flag_pkg::*;

  logic [DATA_W-1:0] a_m, b_m;
  logic [DATA_W-1:0] y_raw;

  assign a_m = a_i & mask_i;
  assign b_m = b_i & mask_i;

  always_comb begin
    x_o       = a_m;
    y_raw     = b_m;
    cin_o     = 1'b0;
    is_sub_o  = 1'b0;
    keep_cf_o = 1'b0;
    valid_o   = 1'b1;
    case (op_i)
      OP_ADD: ;
      OP_ADC: cin_o = cf_i;
      OP_SUB: begin
        y_raw    = ~b_m;
        cin_o    = 1'b1;
        is_sub_o = 1'b1;
      end
      OP_SBB: begin
        y_raw    = ~b_m;
        cin_o    = ~cf_i;
        is_sub_o = 1'b1;
      end
      OP_INC: begin
        y_raw     = DATA_W'(1);
        keep_cf_o = 1'b1;
      end
      OP_DEC: begin
        y_raw     = {DATA_W{1'b1}};
        is_sub_o  = 1'b1;
        keep_cf_o = 1'b1;
      end
      OP_NEG: begin
        x_o      = '0;
        y_raw    = ~a_m;
        cin_o    = 1'b1;
        is_sub_o = 1'b1;
      end
      default: begin
        x_o     = '0;
        y_raw   = '0;
        valid_o = 1'b0;
      end
    endcase
    y_o = y_raw & mask_i;
  end

endmodule

// File: rtl/alu_adder_core.sv
module alu_adder_core #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              cin_i,
  output logic [DATA_W:0]   sum_o,
  output logic [DATA_W:0]   carry_into_o
);
  // carry_into_o[k] is the carry entering bit k; index DATA_W is the final carry out
  assign sum_o        = {1'b0, x_i} + {1'b0, y_i} + {{DATA_W{1'b0}}, cin_i};
  assign carry_into_o = {sum_o[DATA_W], x_i ^ y_i ^ sum_o[DATA_W-1:0]};

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
  parameter int DATA_W = 32,
  parameter int NIB    = 4,
  parameter int PAR_W  = 8
) (
  input  logic [DATA_W:0]   sum_i,
  input  logic [DATA_W:0]   carry_into_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] msb_sel_i,
  input  logic              is_sub_i,
  input  logic              keep_cf_i,
  input  logic              valid_i,
  input  logic [5:0]        flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [5:0]        flags_o,
  output logic [5:0]        wmask_o
);
  import alu_flag_pkg::*;

  logic [DATA_W-1:0] res;
  logic              cout_msb, cin_msb;
  logic [5:0]        fresh;

  assign res      = sum_i[DATA_W-1:0] & mask_i;
  assign cout_msb = |(carry_into_i[DATA_W:1]   & msb_sel_i);
  assign cin_msb  = |(carry_into_i[DATA_W-1:0] & msb_sel_i);

  always_comb begin
    fresh        = '0;
    fresh[FL_CF] = is_sub_i ^ cout_msb;
    fresh[FL_PF] = ~^res[PAR_W-1:0];
    fresh[FL_AF] = is_sub_i ^ carry_into_i[NIB];
    fresh[FL_ZF] = (res == '0);
    fresh[FL_SF] = |(res & msb_sel_i);
    fresh[FL_OF] = cout_msb ^ cin_msb;
  end

  assign wmask_o  = !valid_i ? 6'b000000 : (keep_cf_i ? 6'b111110 : 6'b111111);
  assign flags_o  = (fresh & wmask_o) | (flags_i & ~wmask_o);
  assign result_o = valid_i ? res : '0;

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [5:0]        flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [5:0]        flags_o,
  output logic [5:0]        flag_mask_o
);
  import alu_flag_pkg::*;

  localparam int QW = DATA_W / 4;

  logic [DATA_W-1:0] mask, msb_sel, x, y, res_c;
  logic              cin, is_sub, keep_cf, valid;
  logic [DATA_W:0]   sum, carry_into;
  logic [5:0]        flags_c, wmask_c;

  alu_size_decode #(.DATA_W(DATA_W)) i_size (
    .size_i(size_i), .mask_o(mask), .msb_sel_o(msb_sel)
  );

  alu_operand_prep #(.DATA_W(DATA_W)) i_prep (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .cf_i(flags_i[FL_CF]), .mask_i(mask),
    .x_o(x), .y_o(y), .cin_o(cin), .is_sub_o(is_sub), .keep_cf_o(keep_cf),
    .valid_o(valid)
  );

  alu_adder_core #(.DATA_W(DATA_W)) i_add (
    .x_i(x), .y_i(y), .cin_i(cin), .sum_o(sum), .carry_into_o(carry_into)
  );

  alu_flag_gen #(.DATA_W(DATA_W)) i_flags (
    .sum_i(sum), .carry_into_i(carry_into), .mask_i(mask), .msb_sel_i(msb_sel),
    .is_sub_i(is_sub), .keep_cf_i(keep_cf), .valid_i(valid), .flags_i(flags_i),
    .result_o(res_c), .flags_o(flags_c), .wmask_o(wmask_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o    <= '0;
      flags_o     <= '0;
      flag_mask_o <= '0;
    end else begin
      result_o    <= res_c;
      flags_o     <= flags_c;
      flag_mask_o <= wmask_c;
    end
  end

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (size_i == SZ_Q) |=> (result_o[DATA_W-1:QW] == '0));

  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (rst)
    flag_mask_o[FL_ZF] |-> (flags_o[FL_ZF] == (result_o == '0)));

  assert_parity_low_byte_R6: assert property (@(posedge clk) disable iff (rst)
    flag_mask_o[FL_PF] |-> (flags_o[FL_PF] == ~^result_o[7:0]));

  assert_keep_carry_R8: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_INC || op_i == OP_DEC) |=>
      (!flag_mask_o[FL_CF] && flags_o[FL_CF] == $past(flags_i[FL_CF])));

  assert_neg_zero_no_carry_R9: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NEG && (a_i & mask) == '0) |=> (!flags_o[FL_CF] && result_o == '0));

  assert_idle_op_R10: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NONE) |=> (flag_mask_o == 6'b0 && result_o == '0 &&
                           flags_o == $past(flags_i)));

endmodule

// File: tb/test_alu_flag_unit.sv
`timescale 1ns/1ps
module test_alu_flag_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [5:0]  flags_i = '0;
  logic [31:0] result_o;
  logic [5:0]  flags_o, flag_mask_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  alu_flag_unit i_alu_flag_unit (
    .clk(clk), .rst(rst), .op_i(op_i), .size_i(size_i), .a_i(a_i), .b_i(b_i),
    .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o),
    .flag_mask_o(flag_mask_o)
  );

  // Reference: plain integer arithmetic at the selected size
  function automatic void ref_model(input logic [2:0] op, input logic [1:0] sz,
                                    input logic [31:0] a, input logic [31:0] b,
                                    input logic [5:0] fin,
                                    output logic [31:0] r, output logic [5:0] f,
                                    output logic [5:0] m);
    longint n, lim, half, ua, ub, c, mu, su, cc, tot, st, sm, ss, resv;
    logic cf, of, af;
    n    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    lim  = longint'(1) << n;
    half = lim / 2;
    ua   = longint'(a) % lim;
    ub   = longint'(b) % lim;
    c    = longint'(fin[0]);
    if (op == 3'd7) begin
      r = '0; f = fin; m = '0;
      return;
    end
    if (op == 3'd0 || op == 3'd1 || op == 3'd4) begin
      mu = ua;
      su = (op == 3'd4) ? 1 : ub;
      cc = (op == 3'd1) ? c : 0;
      tot  = mu + su + cc;
      cf   = (tot >= lim);
      resv = tot % lim;
      sm = (mu >= half) ? mu - lim : mu;
      ss = (su >= half) ? su - lim : su;
      st = sm + ss + cc;
      af = ((mu % 16) + (su % 16) + cc) > 15;
    end else begin
      mu = (op == 3'd6) ? 0 : ua;
      su = (op == 3'd6) ? ua : (op == 3'd5) ? 1 : ub;
      cc = (op == 3'd3) ? c : 0;
      cf   = (mu < su + cc);
      resv = (mu - su - cc + 2 * lim) % lim;
      sm = (mu >= half) ? mu - lim : mu;
      ss = (su >= half) ? su - lim : su;
      st = sm - ss - cc;
      af = (mu % 16) < ((su % 16) + cc);
    end
    of = (st >= half) || (st < -half);
    r  = 32'(resv);
    f  = {of, (resv >= half), (resv == 0), af, ~^r[7:0], cf};
    m  = 6'b111111;
    if (op == 3'd4 || op == 3'd5) begin
      f[0] = fin[0];
      m    = 6'b111110;
    end
  endfunction

  // Called at a falling edge; result is registered at the next rising edge
  task automatic run(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] a,
                     input logic [31:0] b, input logic [5:0] fin, input string tag);
    logic [31:0] er;
    logic [5:0]  ef, em;
    op_i = op; size_i = sz; a_i = a; b_i = b; flags_i = fin;
    ref_model(op, sz, a, b, fin, er, ef, em);
    @(negedge clk);
    n_tests++;
    if (result_o !== er || flags_o !== ef || flag_mask_o !== em) begin
      n_fail++;
      $display("FAIL %s op=%0d sz=%0d a=%h b=%h fin=%b: got r=%h f=%b m=%b exp r=%h f=%b m=%b",
               tag, op, sz, a, b, fin, result_o, flags_o, flag_mask_o, er, ef, em);
    end
  endtask

  task automatic expect_eq(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lo, hi;
    logic [5:0]  fl;
    logic [31:0] corner [10];
    // R11: reset clears outputs even with live inputs
    op_i = 3'd0; size_i = 2'd0; a_i = 32'hFF; b_i = 32'h1; flags_i = 6'h3F;
    repeat (3) @(negedge clk);
    expect_eq({26'd0, result_o, flags_o, flag_mask_o}, 64'd0, "R11 reset state");
    rst = 1'b0;

    // Directed corners
    run(3'd0, 2'd0, 32'hFF, 32'h1, 6'h0, "R2 R5 R6 byte FF+1");
    expect_eq({58'd0, flags_o}, {58'd0, 6'b001111}, "R2 R4 R5 R6 FF+1 flag pattern");
    run(3'd0, 2'd0, 32'h7F, 32'h1, 6'h0, "R3 R4 byte 7F+1");
    expect_eq({58'd0, flags_o[5], flags_o[4]}, 64'd3, "R3 R4 7F+1 OF and SF");
    run(3'd6, 2'd0, 32'h80, 32'h0, 6'h0, "R9 negate most negative");
    expect_eq({62'd0, flags_o[5], flags_o[0]}, 64'd3, "R9 negate 80 OF and CF");
    run(3'd6, 2'd1, 32'hABCD0000, 32'h0, 6'h1, "R9 R1 negate zero with upper junk");
    expect_eq({63'd0, flags_o[0]}, 64'd0, "R9 negate zero clears carry");
    run(3'd4, 2'd2, 32'hFFFFFFFF, 32'h0, 6'h1, "R8 increment keeps carry set");
    run(3'd5, 2'd2, 32'h0, 32'h0, 6'h0, "R8 decrement keeps carry clear");
    expect_eq({63'd0, flags_o[0]}, 64'd0, "R8 decrement borrow not in carry");
    run(3'd7, 2'd0, 32'h12, 32'h34, 6'b101010, "R10 idle op");
    run(3'd2, 2'd0, 32'hDEAD0010, 32'hBEEF0011, 6'h0, "R1 R2 upper bits ignored");
    expect_eq({32'd0, result_o}, 64'h0000_0000_0000_00FF, "R1 upper result bits zero");

    // R7: 64-bit add and subtract by chaining through the carry flag
    run(3'd0, 2'd2, 32'hFFFF_FFF0, 32'h0000_0020, 6'h0, "R7 chain add low");
    lo = result_o; fl = flags_o;
    run(3'd1, 2'd2, 32'h1234_5678, 32'h0000_0001, fl, "R7 chain add high");
    hi = result_o;
    expect_eq({hi, lo}, 64'h1234_5678_FFFF_FFF0 + 64'h0000_0001_0000_0020, "R7 64-bit sum");
    run(3'd2, 2'd2, 32'h0000_0005, 32'h0000_0009, 6'h0, "R7 chain sub low");
    lo = result_o; fl = flags_o;
    run(3'd3, 2'd2, 32'h0000_0010, 32'h0000_0003, fl, "R7 chain sub high");
    hi = result_o;
    expect_eq({hi, lo}, 64'h0000_0010_0000_0005 - 64'h0000_0003_0000_0009, "R7 64-bit difference");

    // Byte sweep of binary forms with junk above the byte
    for (int cf = 0; cf < 2; cf++)
      for (int op = 0; op < 4; op++)
        for (int a = 0; a < 256; a++)
          for (int b = 0; b < 256; b += 7)
            run(3'(op), 2'd0, {24'(a * 7919 ^ b * 104729), 8'(a)},
                {24'(a * 31 + b * 977), 8'(b)}, {5'(a + b), 1'(cf)},
                "R1 R2 R3 R4 R5 R6 R7 byte binary sweep");

    // Byte sweep of unary forms and idle
    for (int cf = 0; cf < 2; cf++)
      for (int op = 4; op < 8; op++)
        for (int a = 0; a < 256; a++)
          run(3'(op), 2'd0, {24'(a * 40503), 8'(a)}, 32'(a * 3), {5'(a), 1'(cf)},
              "R8 R9 R10 byte unary sweep");

    // Corner crossing at 16 and 32 bits
    for (int s = 1; s < 4; s += 2) begin
      logic [31:0] lim_m1;
      lim_m1 = (s == 1) ? 32'h0000FFFF : 32'hFFFFFFFF;
      corner[0] = 32'h0;  corner[1] = 32'h1;  corner[2] = 32'h2;
      corner[3] = lim_m1 >> 1; corner[4] = (lim_m1 >> 1) + 1; corner[5] = (lim_m1 >> 1) + 2;
      corner[6] = lim_m1; corner[7] = lim_m1 - 1; corner[8] = 32'hF; corner[9] = 32'h10;
      for (int cf = 0; cf < 2; cf++)
        for (int op = 0; op < 7; op++)
          for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
              run(3'(op), 2'(s), corner[i] | ((s == 1) ? 32'h5A5A0000 : 32'h0), corner[j],
                  {5'(i + j), 1'(cf)}, "R1 R2 R3 R4 R5 R9 wide corner sweep");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule